// File: doc/BRIEF.md
# Receive Queue Congestion Monitor

This block observes how full a receive input buffer is whenever a packet arrives. It keeps a 16-bit count of arrivals that found the buffer at or above a depth limit. The count stops at full scale, slowly drains when software stops looking at it, and raises a sticky interrupt flag once it reaches a programmable congestion limit. Software sees the count and the limit as one 32-bit status word, and it can write both fields. The count is cleared through the interrupt flag, by writing one to it, and not through its own field.

A leak timer sets the drain rate. It runs freely with a period of 2^(10+sel) clocks, where sel is a 3-bit selector. Every read of the status word restarts it. Each time a full period passes with no read, the count drops by one. The buffer depth limit and the leak selector arrive as plain inputs from the surrounding register file.

Top module: `rxq_cong_mon`

## Requirements
- R1: On a clock with `pkt_rx_i` high, `bufs_used_i >= depth_thr_i` and a nonzero congestion limit, the count (status bits 31:16) rises by one on the next edge. With `bufs_used_i < depth_thr_i` it does not rise.
- R2: The count holds at 0xFFFF and goes no higher until it is cleared, loaded or leaked.
- R3: While the congestion limit (status bits 15:0) is zero, arriving packets never raise the count.
- R4: A pulse on `irq_clr_i` sets the count to 0 on the next edge. It wins over a status write in the same cycle, although the limit field of that write is still taken.
- R5: Once the limit is nonzero and the count is at or above it, `irq_stat_o` is high one edge later.
- R6: `irq_o` is high exactly when both `irq_stat_o` and `irq_en_i` are high.
- R7: Each run of 2^(10+`leak_sel_i`) consecutive clocks without `reg_rd_i` lowers the count by one, but never below 0. A clock with `reg_rd_i` high restarts the run.
- R8: When a leak and a qualifying packet fall in the same cycle, the count stays unchanged.
- R9: A status write with `reg_wr_i` loads the count from bits 31:16 and the limit from bits 15:0. The write wins over a packet or a leak in the same cycle.
- R10: `reg_rdata_o` is {count, limit}, and both fields are 0 after reset. `irq_stat_o` is also 0 after reset.
- R11: `irq_stat_o` stays high until `irq_clr_i`, even after the count falls below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_rx_i | input | 1 | One-cycle strobe per received packet |
| bufs_used_i | input | 8 | Buffers currently in use |
| depth_thr_i | input | 8 | Buffer depth limit |
| leak_sel_i | input | 3 | Leak period selector, period 2^(10+sel) clocks |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_rd_i | input | 1 | Read strobe for the status word |
| reg_wdata_i | input | 32 | Write data: count in 31:16, limit in 15:0 |
| reg_rdata_o | output | 32 | Readback: count in 31:16, limit in 15:0 |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag; also clears the count |
| irq_en_i | input | 1 | Interrupt mask enable |
| irq_stat_o | output | 1 | Sticky interrupt status flag |
| irq_o | output | 1 | Masked interrupt line |

## Verification
A wrong count shows on `reg_rdata_o` one edge after the event that caused it, because the readback is read straight from the registers. A flag that is set late, set wrongly or dropped shows on `irq_stat_o` one edge behind the count. Leak faults, such as a wrong period or a missed restart, stay hidden until the first period boundary. The bench therefore runs long read-free stretches of 1024 and 2048 clocks and lines a packet up on the exact leak cycle. Random phases then mix rare reads, writes and clears so that the priority order is exercised under many different input combinations.

// File: rtl/rxq_cong_pkg.sv
package rxq_cong_pkg;

    // Operation applied to the congestion count on one edge
    typedef enum logic [2:0] {
        CNT_HOLD  = 3'd0,
        CNT_CLEAR = 3'd1,
        CNT_LOAD  = 3'd2,
        CNT_UP    = 3'd3,
        CNT_DOWN  = 3'd4
    } cnt_op_e;

    // Raw requests that compete for the count in one cycle
    typedef struct packed {
        logic clr;
        logic load;
        logic up;
        logic down;
    } cnt_req_t;

    // Priority: clear, then software load, then up/down (which cancel each other)
    function automatic cnt_op_e pick_op(input cnt_req_t r);
        cnt_op_e op;
        if (r.clr)                op = CNT_CLEAR;
        else if (r.load)          op = CNT_LOAD;
        else if (r.up && r.down)  op = CNT_HOLD;
        else if (r.up)            op = CNT_UP;
        else if (r.down)          op = CNT_DOWN;
        else                      op = CNT_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/rxq_leak_timer.sv
module rxq_leak_timer #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             restart_i,
    output logic             leak_o
);
    localparam int TMR_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W:0]   span;
    logic [TMR_W-1:0] last;
    int unsigned      shamt;

    always_comb begin
        shamt  = BASE_LOG2 + int'(sel_i);
        span   = {{TMR_W{1'b0}}, 1'b1} << shamt;
        last   = TMR_W'(span - 1'b1);
        leak_o = !restart_i && (tmr_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst)                       tmr_q <= '0;
        else if (restart_i || leak_o)  tmr_q <= '0;
        else                           tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/rxq_depth_detect.sv
module rxq_depth_detect #(
    parameter int OCC_W = 8
) (
    input  logic             pkt_i,
    input  logic [OCC_W-1:0] used_i,
    input  logic [OCC_W-1:0] depth_i,
    input  logic             enable_i,
    output logic             hit_o
);
    always_comb hit_o = pkt_i && enable_i && (used_i >= depth_i);
endmodule

// File: rtl/rxq_cong_counter.sv
module rxq_cong_counter
    import rxq_cong_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_req_t         req_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_op_e          op;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        op = pick_op(req_i);
        unique case (op)
            CNT_CLEAR: cnt_d = '0;
            CNT_LOAD:  cnt_d = load_i;
            CNT_UP:    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            CNT_DOWN:  cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rxq_irq_flag.sv
module rxq_irq_flag #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             clr_i,
    output logic             flag_o
);
    logic flag_q;
    logic reach;

    always_comb reach = (lim_i != '0) && (cnt_i >= lim_i);

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (clr_i) flag_q <= 1'b0;
        else if (reach) flag_q <= 1'b1;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rxq_cong_mon.sv
module rxq_cong_mon
    import rxq_cong_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int OCC_W     = 8,
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 10,
    localparam int WORD_W   = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_rx_i,
    input  logic [OCC_W-1:0]  bufs_used_i,
    input  logic [OCC_W-1:0]  depth_thr_i,
    input  logic [SEL_W-1:0]  leak_sel_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    input  logic              irq_clr_i,
    input  logic              irq_en_i,
    output logic              irq_stat_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit_w;
    logic             leak_w;
    cnt_req_t         req;

    always_ff @(posedge clk) begin
        if (rst)           thr_q <= '0;
        else if (reg_wr_i) thr_q <= reg_wdata_i[CNT_W-1:0];
    end

    rxq_leak_timer #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_tmr (
        .clk(clk), .rst(rst), .sel_i(leak_sel_i),
        .restart_i(reg_rd_i), .leak_o(leak_w)
    );

    rxq_depth_detect #(.OCC_W(OCC_W)) u_det (
        .pkt_i(pkt_rx_i), .used_i(bufs_used_i), .depth_i(depth_thr_i),
        .enable_i(thr_q != '0), .hit_o(hit_w)
    );

    always_comb begin
        req.clr  = irq_clr_i;
        req.load = reg_wr_i;
        req.up   = hit_w;
        req.down = leak_w;
    end

    rxq_cong_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .req_i(req),
        .load_i(reg_wdata_i[WORD_W-1:CNT_W]), .cnt_o(cnt_q)
    );

    rxq_irq_flag #(.CNT_W(CNT_W)) u_flag (
        .clk(clk), .rst(rst), .cnt_i(cnt_q), .lim_i(thr_q),
        .clr_i(irq_clr_i), .flag_o(irq_stat_o)
    );

    assign reg_rdata_o = {cnt_q, thr_q};
    assign irq_o       = irq_stat_o & irq_en_i;
endmodule

// File: rtl/rxq_cong_chk.sv
module rxq_cong_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] thr,
    input logic             leak,
    input logic             stat,
    input logic             irq
);
    assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    assert_hold_at_max_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1 && !clr && !wr && !leak) |=> (cnt == '1));

    assert_no_count_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (thr == '0 && !clr && !wr) |=> (cnt <= $past(cnt)));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (stat && !clr) |=> stat);

    assert_flag_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (thr != '0 && cnt >= thr && !clr) |=> stat);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat);

    assert_unit_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr) |=> (cnt == $past(cnt) ||
                           cnt == $past(cnt) + CNT_W'(1) ||
                           cnt == $past(cnt) - CNT_W'(1)));
endmodule

bind rxq_cong_mon rxq_cong_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .clr(irq_clr_i), .wr(reg_wr_i),
    .cnt(cnt_q), .thr(thr_q), .leak(leak_w),
    .stat(irq_stat_o), .irq(irq_o)
);

// File: tb/sim_rxq_cong_mon.sv
module sim_rxq_cong_mon;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt = 1'b0;
    logic [7:0]  used = '0;
    logic [7:0]  dep = '0;
    logic [2:0]  sel = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        stat;
    logic        irq;

    int unsigned vec = 0;
    int unsigned bad = 0;
    bit          done = 1'b0;

    // reference state
    logic [15:0] m_cnt = '0;
    logic [15:0] m_thr = '0;
    logic        m_stat = 1'b0;
    int unsigned m_tmr = 0;

    always #4 clk = ~clk;

    rxq_cong_mon u0 (
        .clk(clk), .rst(rst), .pkt_rx_i(pkt), .bufs_used_i(used),
        .depth_thr_i(dep), .leak_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_clr_i(clr),
        .irq_en_i(en), .irq_stat_o(stat), .irq_o(irq)
    );

    function automatic int unsigned period(input logic [2:0] s);
        return 32'd1 << (10 + int'(s));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: apply current inputs, advance reference, compare outputs
    task automatic step(input string tag);
        logic        lk, inc;
        logic [15:0] n_cnt, n_thr;
        logic        n_stat;
        lk  = !rd && (m_tmr >= period(sel) - 1);
        inc = pkt && (used >= dep) && (m_thr != 0);
        n_stat = clr ? 1'b0 : (m_stat || (m_thr != 0 && m_cnt >= m_thr));
        n_thr  = wr ? wdata[15:0] : m_thr;
        if (clr)             n_cnt = '0;
        else if (wr)         n_cnt = wdata[31:16];
        else if (inc && lk)  n_cnt = m_cnt;
        else if (inc)        n_cnt = (m_cnt == 16'hFFFF) ? m_cnt : m_cnt + 1'b1;
        else if (lk)         n_cnt = (m_cnt == 0) ? m_cnt : m_cnt - 1'b1;
        else                 n_cnt = m_cnt;
        @(posedge clk);
        m_tmr  = (rd || lk) ? 0 : m_tmr + 1;
        m_cnt  = n_cnt;
        m_thr  = n_thr;
        m_stat = n_stat;
        #2;
        chk({tag, " word"}, rdata, {m_cnt, m_thr});
        chk({tag, " flag"}, {31'd0, stat}, {31'd0, m_stat});
        chk({tag, " R6 irq"}, {31'd0, irq}, {31'd0, m_stat & en});
        @(negedge clk);
        pkt = 0; wr = 0; clr = 0;
    endtask

    task automatic write_word(input logic [15:0] c, input logic [15:0] t, input string tag);
        wr = 1; wdata = {c, t};
        step(tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        #2;
        // R10: reset state
        chk("R10 reset word", rdata, 32'h0);
        chk("R10 reset flag", {31'd0, stat}, 32'h0);
        rst = 0;
        @(negedge clk);
        rd = 1;

        // R3: zero limit blocks counting
        used = 8'd9; dep = 8'd4;
        for (int i = 0; i < 5; i++) begin pkt = 1; step("R3 off"); end

        // R9: write loads both fields
        write_word(16'h0000, 16'h0003, "R9 load");
        // R1: below depth does not count
        used = 8'd3; dep = 8'd4;
        for (int i = 0; i < 3; i++) begin pkt = 1; step("R1 below"); end
        // R1: at and above depth counts; R5 flag follows
        used = 8'd4;
        for (int i = 0; i < 3; i++) begin pkt = 1; step("R1 equal"); end
        used = 8'd200;
        en = 0; step("R5 flag");
        en = 1; step("R6 unmask");

        // R11: sticky after count drops
        write_word(16'h0001, 16'h0003, "R11 drop");
        for (int i = 0; i < 3; i++) step("R11 sticky");

        // R4: clear, and clear beating write
        clr = 1; step("R4 clear");
        step("R4 after");
        clr = 1; write_word(16'h1234, 16'h0007, "R4 vs write");

        // R9: write beats increment
        pkt = 1; write_word(16'h0020, 16'h0007, "R9 vs inc");

        // R2: saturation
        write_word(16'hFFFD, 16'hFFFF, "R2 preload");
        for (int i = 0; i < 6; i++) begin pkt = 1; step("R2 sat"); end
        clr = 1; step("R2 clear");

        // R7: leak at shortest period, read-free
        write_word(16'h0005, 16'h0100, "R7 preload");
        rd = 0; sel = 3'd0;
        for (int i = 0; i < 1030; i++) step("R7 leak p0");
        // R7: read restarts the run
        for (int i = 0; i < 500; i++) step("R7 pre-read");
        rd = 1; step("R7 read"); rd = 0;
        for (int i = 0; i < 1030; i++) step("R7 restart");
        // R8: packet on the leak cycle
        while (m_tmr < period(sel) - 1) step("R8 wait");
        pkt = 1; used = 8'd50; dep = 8'd1;
        step("R8 cancel");
        // R7: longer period
        sel = 3'd1;
        for (int i = 0; i < 2100; i++) step("R7 leak p1");
        // R7: floor at zero
        write_word(16'h0000, 16'h0100, "R7 zero");
        sel = 3'd0;
        for (int i = 0; i < 1100; i++) step("R7 floor");

        // Random mix
        for (int i = 0; i < 30000; i++) begin
            pkt   = ($urandom % 3) == 0;
            used  = 8'($urandom % 16);
            dep   = 8'($urandom % 16);
            rd    = ($urandom % 200) == 0;
            sel   = 3'($urandom % 2);
            en    = ($urandom % 4) != 0;
            clr   = ($urandom % 300) == 0;
            wr    = ($urandom % 250) == 0;
            wdata = {16'($urandom % 12), 16'($urandom % 10)};
            step("R1 R7 R8 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule